// File: doc/BRIEF.md
# 1-Wire Single-Sensor Temperature Reader

This block runs one complete temperature read from a single sensor on a 1-Wire bus. A one-cycle `start` pulse launches a fixed transaction. The block resets the bus and listens for a presence answer. It then issues the skip-device-address command and the convert command, and waits out the conversion time. Next it issues skip-address again, followed by the scratchpad read, and collects twelve raw temperature bits. The bus is open-drain: the block only ever pulls the line low, through `line_drive`, and it reads the resolved level back on `line_in`.

All bus timing is counted in whole microseconds. The microseconds come from a divider of `CLKS_PER_US` system clocks, and this divider restarts at the first cycle of every phase. Each phase therefore lasts exactly its length in microseconds times `CLKS_PER_US` cycles, with no hidden cycles where one phase hands over to the next.

The result is a data output with no back-pressure. `temp_valid` is high for a single cycle, and in that cycle `temp_raw` is valid. The value then stays unchanged until the next valid pulse, so a consumer has no ready signal to return. If no device answers the reset, `no_device` pulses instead.

Top module: `owire_temp_reader`

## Requirements
- R1: A `start` pulse seen while idle begins a reset phase in the next cycle. The line is pulled low for 480 µs, then released, and the whole phase lasts 960 µs. One microsecond is `CLKS_PER_US` clock cycles.
- R2: A device is present if the line reads 0 at any time during the released part of the reset phase. If no device is present, `no_device` is high for exactly one cycle when the reset phase ends, the block returns to idle, and no command slot is issued.
- R3: When a device is present, command bytes go out in this order: 0xCC, 0x44, then a conversion wait of `CONV_US` µs, then 0xCC, 0xBE. Each byte is sent least-significant bit first, one bit per 65 µs slot. The first slot starts right at the end of the reset phase, and every following slot starts exactly 65 µs after the one before it, except that the conversion wait is inserted after the second byte.
- R4: In a write slot, a 1 bit pulls the line low for exactly 6 µs and a 0 bit pulls it low for exactly 60 µs. The line is released for the rest of the slot.
- R5: After the last command bit come twelve read slots of 65 µs each. Each slot pulls the line low for 2 µs and samples the line 15 µs after the slot starts. The first bit read lands in `temp_raw[0]` and the last in `temp_raw[11]`.
- R6: `temp_valid` is high for exactly one cycle, 65 µs after the start of the last read slot. In that cycle the block returns to idle. `temp_raw` holds the value until the next valid pulse.
- R7: A `start` pulse that arrives while a transaction is in progress is ignored. It causes no new reset phase and no extra result.
- R8: After `rst`, and whenever the block is idle, `line_drive` is 0. After `rst`, `temp_valid`, `no_device` and `temp_raw` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a read |
| line_in | input | 1 | Resolved 1-Wire line level |
| line_drive | output | 1 | 1 pulls the line low; 0 releases it |
| temp_raw | output | TEMP_W (12) | Raw temperature, LSB first bit received |
| temp_valid | output | 1 | One-cycle pulse when `temp_raw` is new |
| no_device | output | 1 | One-cycle pulse when no presence was seen |

## Verification
The bench measures every low pulse and the spacing between slot starts in exact cycles. A delay counter that slips by a cycle or two on re-entry, as a load-then-decrement timer does, shows up as a wrong slot-to-slot spacing. The same happens if the conversion wait is too long or too short. The 0xCC/0x44/0xCC/0xBE sequence is decoded from the pulse widths, so a byte sent MSB first or a 1/0 width swap shows up at once. Read values with mixed bit patterns catch a result shifted in the wrong direction. A missing device must produce the error pulse and no command slots. A start issued mid-transaction must not trigger a second reset or a stray result.

// File: rtl/owt_pkg.sv
`timescale 1ns/1ps
package owt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_WRITE,
    ST_CONV,
    ST_READ
  } owt_state_e;

  localparam logic [7:0] CMD_SKIP_ADDR = 8'hCC;
  localparam logic [7:0] CMD_CONVERT   = 8'h44;
  localparam logic [7:0] CMD_READ_PAD  = 8'hBE;

  // Byte sent at each position of the fixed command sequence.
  function automatic logic [7:0] cmd_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return CMD_SKIP_ADDR;
      2'd1:    return CMD_CONVERT;
      2'd2:    return CMD_SKIP_ADDR;
      default: return CMD_READ_PAD;
    endcase
  endfunction
endpackage

// File: rtl/owt_tick_gen.sv
`timescale 1ns/1ps
module owt_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] div_q;

  assign tick = (div_q == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/owt_us_count.sv
`timescale 1ns/1ps
module owt_us_count #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] us
);
  always_ff @(posedge clk) begin
    if (rst || clr) us <= '0;
    else if (tick)  us <= us + 1'b1;
  end
endmodule

// File: rtl/owt_rx_shift.sv
`timescale 1ns/1ps
module owt_rx_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  // New bits enter at the top, so the first bit ends at index 0.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/owire_temp_reader.sv
`timescale 1ns/1ps
module owire_temp_reader
  import owt_pkg::*;
#(
  parameter int CLKS_PER_US  = 50,
  parameter int RST_LOW_US   = 480,
  parameter int RST_US       = 960,
  parameter int SLOT_US      = 65,
  parameter int W1_LOW_US    = 6,
  parameter int W0_LOW_US    = 60,
  parameter int RD_LOW_US    = 2,
  parameter int RD_SAMPLE_US = 15,
  parameter int CONV_US      = 750000,
  parameter int TEMP_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              line_in,
  output logic              line_drive,
  output logic [TEMP_W-1:0] temp_raw,
  output logic              temp_valid,
  output logic              no_device
);
  localparam int LONG1   = (RST_US > SLOT_US) ? RST_US : SLOT_US;
  localparam int LONGEST = (CONV_US > LONG1) ? CONV_US : LONG1;
  localparam int US_W    = $clog2(LONGEST + 1);
  localparam int BITS_MAX = (TEMP_W > 8) ? TEMP_W : 8;
  localparam int IDX_W   = $clog2(BITS_MAX);
  localparam int NUM_CMDS   = 4;
  localparam int CONV_AFTER = 1;

  owt_state_e        state;
  logic              tick;
  logic              restart;
  logic              phase_done;
  logic [US_W-1:0]   us_cnt;
  logic [US_W-1:0]   phase_last;
  logic [1:0]        byte_idx;
  logic [IDX_W-1:0]  bit_idx;
  logic              seen;
  logic              cur_bit;
  logic              sample_en;
  logic [TEMP_W-1:0] shift_q;

  // Timers restart on every phase boundary so each phase is exact.
  assign restart = (state == ST_IDLE) || phase_done;

  owt_tick_gen #(.DIV(CLKS_PER_US)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .tick(tick)
  );

  owt_us_count #(.W(US_W)) u_us (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .tick(tick),
    .us  (us_cnt)
  );

  always_comb begin
    case (state)
      ST_RESET: phase_last = US_W'(RST_US - 1);
      ST_CONV:  phase_last = US_W'(CONV_US - 1);
      default:  phase_last = US_W'(SLOT_US - 1);
    endcase
  end

  assign phase_done = (state != ST_IDLE) && tick && (us_cnt == phase_last);

  assign cur_bit   = cmd_byte(byte_idx)[bit_idx[2:0]];
  assign sample_en = (state == ST_READ) && tick && (us_cnt == US_W'(RD_SAMPLE_US - 1));

  owt_rx_shift #(.W(TEMP_W)) u_rx (
    .clk(clk),
    .rst(rst),
    .en (sample_en),
    .din(line_in),
    .q  (shift_q)
  );

  always_comb begin
    case (state)
      ST_RESET: line_drive = (us_cnt < US_W'(RST_LOW_US));
      ST_WRITE: line_drive = cur_bit ? (us_cnt < US_W'(W1_LOW_US))
                                     : (us_cnt < US_W'(W0_LOW_US));
      ST_READ:  line_drive = (us_cnt < US_W'(RD_LOW_US));
      default:  line_drive = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      byte_idx   <= '0;
      bit_idx    <= '0;
      seen       <= 1'b0;
      temp_raw   <= '0;
      temp_valid <= 1'b0;
      no_device  <= 1'b0;
    end else begin
      temp_valid <= 1'b0;
      no_device  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RESET;
            seen     <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
          end
        end
        ST_RESET: begin
          if (us_cnt >= US_W'(RST_LOW_US) && !line_in) seen <= 1'b1;
          if (phase_done) begin
            if (seen) begin
              state <= ST_WRITE;
            end else begin
              state     <= ST_IDLE;
              no_device <= 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (phase_done) begin
            if (bit_idx == IDX_W'(7)) begin
              bit_idx  <= '0;
              byte_idx <= byte_idx + 2'd1;
              if (byte_idx == 2'(CONV_AFTER))        state <= ST_CONV;
              else if (byte_idx == 2'(NUM_CMDS - 1)) state <= ST_READ;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ST_CONV: begin
          if (phase_done) state <= ST_WRITE;
        end
        ST_READ: begin
          if (phase_done) begin
            if (bit_idx == IDX_W'(TEMP_W - 1)) begin
              state      <= ST_IDLE;
              bit_idx    <= '0;
              temp_raw   <= shift_q;
              temp_valid <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owt_checker.sv
`timescale 1ns/1ps
module owt_checker
  import owt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       line_drive,
  input logic       temp_valid,
  input logic       no_device,
  input owt_state_e state
);
  // R8: bus released whenever the sequencer is idle
  a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !line_drive);

  // R1: start from idle enters the reset phase next cycle
  a_r1_start_enters_reset: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (state == ST_RESET));

  // R6: ready pulse lasts one cycle and coincides with the return to idle
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    temp_valid |=> !temp_valid);
  a_r6_valid_in_idle: assert property (@(posedge clk) disable iff (rst)
    temp_valid |-> (state == ST_IDLE));

  // R2: error pulse lasts one cycle and never meets a result
  a_r2_error_one_cycle: assert property (@(posedge clk) disable iff (rst)
    no_device |=> !no_device);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(temp_valid && no_device));

  // R7: once past the reset phase, no new reset phase starts mid-transaction
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_RESET) |=> (state != ST_RESET));
endmodule

bind owire_temp_reader owt_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .line_drive(line_drive),
  .temp_valid(temp_valid),
  .no_device (no_device),
  .state     (state)
);

// File: tb/owire_temp_reader_test.sv
`timescale 1ns/1ps
module owire_temp_reader_test;
  localparam int C     = 2;
  localparam int CONV  = 100;
  localparam int RLOW  = 480;
  localparam int RTOT  = 960;
  localparam int SLOT  = 65;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dev_pull = 1'b0;
  logic        line_in;
  logic        line_drive;
  logic [11:0] temp_raw;
  logic        temp_valid;
  logic        no_device;

  assign line_in = !(line_drive || dev_pull);

  owire_temp_reader #(.CLKS_PER_US(C), .CONV_US(CONV)) uut (
    .clk(clk), .rst(rst), .start(start), .line_in(line_in),
    .line_drive(line_drive), .temp_raw(temp_raw),
    .temp_valid(temp_valid), .no_device(no_device)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sensor model state
  bit          dev_present = 1'b1;
  logic [11:0] dev_val = '0;
  int          n_resets = 0;
  int          n_slots = 0;
  int          prev_t = 0;
  int          last_read_t = 0;
  logic [31:0] cmd_bits = '0;

  // Scoreboard
  typedef struct { bit err; logic [11:0] val; } exp_t;
  exp_t q[$];
  int   done_cnt = 0;

  // Sensor model: measures each low pulse in cycles and answers on the bus.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && line_drive) begin
        int  t0;
        int  w;
        bit  rd_zero;
        t0 = cyc;
        rd_zero = (n_slots >= 32 && n_slots < 44) && !dev_val[n_slots - 32];
        if (rd_zero) dev_pull = 1'b1;
        w = 0;
        while (line_drive) begin
          w++;
          @(negedge clk);
        end
        if (w >= 200 * C) begin
          n_resets++;
          chk(w == RLOW * C, "R1 reset low width", w, RLOW * C);
          n_slots = 0;
          prev_t  = t0;
          if (dev_present) begin
            repeat (30 * C) @(negedge clk);
            dev_pull = 1'b1;
            repeat (120 * C) @(negedge clk);
            dev_pull = 1'b0;
          end
        end else if (n_slots < 32) begin
          int  gap;
          bit  bv;
          gap = (n_slots == 0) ? RTOT * C : (n_slots == 16) ? (SLOT + CONV) * C : SLOT * C;
          chk(t0 - prev_t == gap, "R3 slot start spacing", t0 - prev_t, gap);
          bv = (w < 15 * C);
          cmd_bits[n_slots] = bv;
          chk(w == (bv ? 6 : 60) * C, "R4 write low width", w, (bv ? 6 : 60) * C);
          prev_t = t0;
          n_slots++;
          if (n_slots == 32)
            chk(cmd_bits == 32'hBECC44CC, "R3 command bytes", cmd_bits, 32'hBECC44CC);
        end else if (n_slots < 44) begin
          chk(t0 - prev_t == SLOT * C, "R5 read slot spacing", t0 - prev_t, SLOT * C);
          chk(w == 2 * C, "R5 read low width", w, 2 * C);
          if (rd_zero) begin
            repeat (30 * C - w) @(negedge clk);
            dev_pull = 1'b0;
          end
          prev_t = t0;
          last_read_t = t0;
          n_slots++;
        end else begin
          chk(1'b0, "R6 slot after last read", n_slots, 44);
        end
      end
    end
  end

  // Monitor: pops expected outcomes as the design reports them.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (temp_valid || no_device)) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected result", {temp_valid, no_device}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.err) begin
            chk(no_device && !temp_valid, "R2 no-presence error", {temp_valid, no_device}, 1);
          end else begin
            chk(temp_valid && temp_raw == e.val, "R5 temperature value", temp_raw, e.val);
            chk(cyc - last_read_t == SLOT * C, "R6 ready timing", cyc - last_read_t, SLOT * C);
          end
        end
        done_cnt++;
      end
    end
  end

  task automatic run_txn(input bit present, input logic [11:0] v, input bit poke_busy);
    int target;
    exp_t e;
    dev_present = present;
    dev_val = v;
    e.err = !present;
    e.val = v;
    q.push_back(e);
    target = done_cnt + 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      repeat (3000) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(!line_drive, "R8 line released after reset", line_drive, 0);
    chk(!temp_valid && !no_device, "R8 pulses low after reset", {temp_valid, no_device}, 0);
    chk(temp_raw == 12'h000, "R8 result cleared", temp_raw, 0);

    run_txn(1'b1, 12'h5A3, 1'b0);
    repeat (20) @(negedge clk);
    chk(temp_raw == 12'h5A3, "R6 result held", temp_raw, 12'h5A3);
    chk(!line_drive, "R8 idle after read", line_drive, 0);

    run_txn(1'b1, 12'h000, 1'b0);
    run_txn(1'b1, 12'hFFF, 1'b0);

    // R2: no device answers
    r0 = n_resets;
    run_txn(1'b0, 12'h000, 1'b0);
    chk(n_resets == r0 + 1, "R2 single reset phase", n_resets, r0 + 1);
    chk(n_slots == 0, "R2 no command slots", n_slots, 0);
    chk(temp_raw == 12'hFFF, "R2 result untouched", temp_raw, 12'hFFF);

    // R7: start during a transaction
    r0 = n_resets;
    run_txn(1'b1, 12'h801, 1'b1);
    repeat (3000) @(negedge clk);
    chk(n_resets == r0 + 1, "R7 busy start ignored", n_resets, r0 + 1);
    chk(!line_drive, "R7 bus idle after ignored start", line_drive, 0);

    run_txn(1'b1, 12'h3C6, 1'b0);
    chk(q.size() == 0, "R6 all results reported", q.size(), 0);
    finish_run();
  end
endmodule